// File: doc/BRIEF.md
# Core Control Register Slave

This block is an AXI4 subordinate that keeps the control and status words of a processor core. Software (or a debug host) writes a reset-control word and a start program counter. The block drives both words straight out to the core, and it returns a status word built from the reset-control value. A second region exposes eight read-only words that the core supplies on its status inputs. Every offset in the window that has no register behind it answers with SLVERR.

The data bus is 128 bits wide and each access is a single beat. Address bits [3:2] select the 32-bit lane that carries the register data, and address bits [1:0] are ignored. The write-address and write-data channels are independent valid/ready streams. Each one is captured once into its own holding register, in either order. The write-response beat is raised only after both have landed and the register update has been made. A pending write response or read beat is back-pressure: while BVALID is held, a new write cannot commit, and while RVALID is held, ARREADY stays low. The reset-control and start-address outputs and the core status inputs are plain level signals.

Top module: `corectl_axi_regs`

## Requirements
- R1: Offset 0x000 is the reset-control word. All 32 bits are writable under per-byte write strobes, and a read returns exactly the bytes written. The word is driven on `core_rstctl_o`.
- R2: After reset, the reset-control word is 0x00000001 and the start address is 0. BVALID and RVALID are low, and AWREADY, WREADY and ARREADY are high.
- R3: Offset 0x008 reads a status word. Bit 0 equals reset-control bit 0 (core held in reset). Bit 1 equals reset-control bit 0 AND reset-control bit 1 (clock gate). All other bits are zero, so the value is always 0, 1 or 3.
- R4: Writes to offsets 0x008 and 0x00C complete with OKAY (BRESP 2'b00) and change no register.
- R5: Reads of every word from 0x00C to 0x0FC complete with SLVERR (RRESP 2'b10) and all-zero RDATA.
- R6: Reads of offsets 0x100 + 4k for k = 0..7 complete with OKAY and return bits [32k+31:32k] of `core_info_i` as sampled at the read-address handshake.
- R7: Reads of every word from 0x120 to 0x1FFC complete with SLVERR and all-zero RDATA.
- R8: A write to any word offset other than 0x000, 0x004, 0x008 or 0x00C completes with SLVERR and changes no register.
- R9: Once BVALID is high it stays high, with BRESP and BID unchanged, until a cycle in which BREADY is high.
- R10: The write-address and write-data beats may be accepted in either order, with any gap between them. BVALID rises only after both have been accepted.
- R11: A read returns one beat with RVALID and RLAST both high. RVALID, RLAST, RDATA, RRESP and RID stay unchanged until RREADY is high.
- R12: Address bits [3:2] pick the 32-bit lane. A read places the word in that lane with the other lanes zero. A write takes its data and byte strobes from that lane only, and ignores data and strobes in the other lanes.
- R13: BID returns the AWID of the write it answers, and RID returns the ARID of the read it answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write-address beat valid |
| s_awready | output | 1 | Write-address holding register empty |
| s_awaddr | input | ADDR_W (13) | Byte offset of the write in the window |
| s_awid | input | ID_W (4) | Write transaction ID |
| s_wvalid | input | 1 | Write-data beat valid |
| s_wready | output | 1 | Write-data holding register empty |
| s_wdata | input | DATA_W (128) | Write data, all lanes |
| s_wstrb | input | DATA_W/8 (16) | Byte strobes, all lanes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response accepted |
| s_bresp | output | 2 | 2'b00 OKAY, 2'b10 SLVERR |
| s_bid | output | ID_W (4) | ID of the answered write |
| s_arvalid | input | 1 | Read-address beat valid |
| s_arready | output | 1 | Read address accepted when high |
| s_araddr | input | ADDR_W (13) | Byte offset of the read in the window |
| s_arid | input | ID_W (4) | Read transaction ID |
| s_rvalid | output | 1 | Read beat valid |
| s_rready | input | 1 | Read beat accepted |
| s_rdata | output | DATA_W (128) | Read data, word in the addressed lane |
| s_rresp | output | 2 | 2'b00 OKAY, 2'b10 SLVERR |
| s_rid | output | ID_W (4) | ID of the answered read |
| s_rlast | output | 1 | Last beat marker, high with every read beat |
| core_info_i | input | N_INFO*32 (256) | Core status words, word k in bits [32k+31:32k] |
| core_rstctl_o | output | 32 | Current reset-control word |
| core_start_pc_o | output | 32 | Current start program counter |

## Verification
Two cases are hard to reach from the ports. The first is a write whose address and data beats arrive in different cycles, in both orders and with gaps, while the response is also held off by a late BREADY. The bench drives the two channels from separate tasks with a chosen order, gap and BREADY delay. It checks that BVALID stays low until the second beat and then stays high for the whole delay. The second case is the status word, which depends on the combination of two reset-control bits. The bench writes each of the four combinations, along with patterns that set unrelated bits, and a long random mix of reads and writes is compared against a behavioural register model on every clock.

// File: rtl/cregs_pkg.sv
package cregs_pkg;

  // Word offsets inside the register window
  localparam int unsigned OFS_CTL  = 32'h000;
  localparam int unsigned OFS_PC   = 32'h004;
  localparam int unsigned OFS_STAT = 32'h008;
  localparam int unsigned OFS_SINK = 32'h00C;
  localparam int unsigned OFS_INFO = 32'h100;

  // Reset-control bit positions that the status word decodes
  localparam int unsigned CTL_HOLD_BIT = 0;
  localparam int unsigned CTL_GATE_BIT = 1;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTL,
    SEL_PC,
    SEL_STAT,
    SEL_SINK,
    SEL_INFO
  } sel_e;

endpackage

// File: rtl/cregs_bank.sv
module cregs_bank
  import cregs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned N_INFO    = 8,
  parameter logic [31:0] CTL_RESET = 32'h0000_0001
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_ofs,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic [WORD_W/8-1:0]      wr_be,
  output logic                     wr_ok,
  input  logic [ADDR_W-1:0]        rd_ofs,
  output logic [WORD_W-1:0]        rd_word,
  output logic                     rd_ok,
  input  logic [N_INFO*WORD_W-1:0] info_i,
  output logic [WORD_W-1:0]        ctl_o,
  output logic [WORD_W-1:0]        pc_o
);

  localparam int unsigned IDX_W    = (N_INFO > 1) ? $clog2(N_INFO) : 1;
  localparam int unsigned INFO_END = OFS_INFO + N_INFO * (WORD_W / 8);
  localparam int unsigned BYTES    = WORD_W / 8;

  function automatic sel_e classify(input logic [ADDR_W-1:0] ofs);
    int unsigned w;
    w = 32'(ofs) & ~32'd3;
    if (w == OFS_CTL)                        return SEL_CTL;
    else if (w == OFS_PC)                    return SEL_PC;
    else if (w == OFS_STAT)                  return SEL_STAT;
    else if (w == OFS_SINK)                  return SEL_SINK;
    else if (w >= OFS_INFO && w < INFO_END)  return SEL_INFO;
    return SEL_NONE;
  endfunction

  sel_e wr_sel, rd_sel;
  assign wr_sel = classify(wr_ofs);
  assign rd_sel = classify(rd_ofs);

  assign wr_ok = (wr_sel == SEL_CTL) || (wr_sel == SEL_PC) ||
                 (wr_sel == SEL_STAT) || (wr_sel == SEL_SINK);

  // Byte-enable expansion
  logic [WORD_W-1:0] bmask;
  for (genvar b = 0; b < BYTES; b++) begin : g_bmask
    assign bmask[b*8 +: 8] = {8{wr_be[b]}};
  end

  logic [WORD_W-1:0] ctl_q, pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
      pc_q  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CTL: ctl_q <= (ctl_q & ~bmask) | (wr_data & bmask);
        SEL_PC:  pc_q  <= (pc_q & ~bmask) | (wr_data & bmask);
        default: ;
      endcase
    end
  end

  assign ctl_o = ctl_q;
  assign pc_o  = pc_q;

  // Status word composed from the reset-control word
  logic [WORD_W-1:0] stat_word;
  always_comb begin
    stat_word    = '0;
    stat_word[0] = ctl_q[CTL_HOLD_BIT];
    stat_word[1] = ctl_q[CTL_HOLD_BIT] & ctl_q[CTL_GATE_BIT];
  end

  // Core-supplied status words
  logic [WORD_W-1:0] info_w [N_INFO];
  for (genvar k = 0; k < N_INFO; k++) begin : g_info
    assign info_w[k] = info_i[k*WORD_W +: WORD_W];
  end

  logic [31:0]      info_rel;
  logic [IDX_W-1:0] info_idx;
  assign info_rel = 32'(rd_ofs) - OFS_INFO;
  assign info_idx = info_rel[IDX_W+1:2];

  always_comb begin
    rd_ok   = 1'b1;
    rd_word = '0;
    case (rd_sel)
      SEL_CTL:  rd_word = ctl_q;
      SEL_PC:   rd_word = pc_q;
      SEL_STAT: rd_word = stat_word;
      SEL_INFO: rd_word = info_w[info_idx];
      default:  rd_ok   = 1'b0;
    endcase
  end

  // A full-strobe write to the control word lands exactly
  assert_ctl_full_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CTL && wr_be == '1) |=> (ctl_o == $past(wr_data)));

  // Writes to the status and spare offsets leave both registers alone
  assert_ro_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_sel == SEL_STAT || wr_sel == SEL_SINK)) |=>
      ($stable(ctl_o) && $stable(pc_o)));

  // Rejected writes leave both registers alone
  assert_bad_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ok) |=> ($stable(ctl_o) && $stable(pc_o)));

endmodule

// File: rtl/cregs_wr_port.sv
module cregs_wr_port
  import cregs_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 128,
  parameter int unsigned ID_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                awvalid,
  output logic                awready,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic [ID_W-1:0]     awid,
  input  logic                wvalid,
  output logic                wready,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  output logic                bvalid,
  input  logic                bready,
  output logic [1:0]          bresp,
  output logic [ID_W-1:0]     bid,
  output logic                commit_o,
  output logic [ADDR_W-1:0]   cm_ofs_o,
  output logic [WORD_W-1:0]   cm_data_o,
  output logic [WORD_W/8-1:0] cm_be_o,
  input  logic                cm_ok_i
);

  localparam int unsigned LANES  = DATA_W / WORD_W;
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int unsigned LBYTES = WORD_W / 8;

  logic                aw_full, w_full;
  logic [ADDR_W-1:0]   aw_addr_q;
  logic [ID_W-1:0]     aw_id_q;
  logic [DATA_W-1:0]   w_data_q;
  logic [DATA_W/8-1:0] w_strb_q;

  assign awready = !aw_full;
  assign wready  = !w_full;

  logic aw_hs, w_hs, commit;
  assign aw_hs  = awvalid && awready;
  assign w_hs   = wvalid && wready;
  assign commit = aw_full && w_full && !bvalid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_full <= 1'b0;
      w_full  <= 1'b0;
      bvalid  <= 1'b0;
      bresp   <= RESP_OKAY;
      bid     <= '0;
    end else begin
      if (aw_hs) aw_full <= 1'b1;
      if (w_hs)  w_full  <= 1'b1;
      if (commit) begin
        aw_full <= 1'b0;
        w_full  <= 1'b0;
        bvalid  <= 1'b1;
        bresp   <= cm_ok_i ? RESP_OKAY : RESP_SLVERR;
        bid     <= aw_id_q;
      end else if (bvalid && bready) begin
        bvalid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (aw_hs) begin
      aw_addr_q <= awaddr;
      aw_id_q   <= awid;
    end
    if (w_hs) begin
      w_data_q <= wdata;
      w_strb_q <= wstrb;
    end
  end

  logic [LANE_W-1:0] lane;
  assign lane = aw_addr_q[LANE_W+1:2];

  assign commit_o  = commit;
  assign cm_ofs_o  = aw_addr_q;
  assign cm_data_o = w_data_q[WORD_W*lane +: WORD_W];
  assign cm_be_o   = w_strb_q[LBYTES*lane +: LBYTES];

  // Response held until taken
  assert_b_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> (bvalid && $stable(bresp) && $stable(bid)));

  // A response appears only once both beats were held
  assert_b_after_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bvalid) |-> ($past(aw_full) && $past(w_full)));

endmodule

// File: rtl/cregs_rd_port.sv
module cregs_rd_port
  import cregs_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 128,
  parameter int unsigned ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [ID_W-1:0]   arid,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic [ID_W-1:0]   rid,
  output logic              rlast,
  output logic [ADDR_W-1:0] lk_ofs_o,
  input  logic [WORD_W-1:0] lk_word_i,
  input  logic              lk_ok_i
);

  localparam int unsigned LANES  = DATA_W / WORD_W;
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  assign arready  = !rvalid;
  assign lk_ofs_o = araddr;

  logic [LANE_W-1:0] lane;
  assign lane = araddr[LANE_W+1:2];

  logic [DATA_W-1:0] placed;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign placed[l*WORD_W +: WORD_W] =
      (lk_ok_i && lane == LANE_W'(l)) ? lk_word_i : '0;
  end

  logic ar_hs;
  assign ar_hs = arvalid && arready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
      rresp  <= RESP_OKAY;
      rid    <= '0;
    end else if (ar_hs) begin
      rvalid <= 1'b1;
      rdata  <= placed;
      rresp  <= lk_ok_i ? RESP_OKAY : RESP_SLVERR;
      rid    <= arid;
    end else if (rvalid && rready) begin
      rvalid <= 1'b0;
    end
  end

  assign rlast = rvalid;

  // Read beat held until taken
  assert_r_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && rlast && $stable(rdata) &&
                             $stable(rresp) && $stable(rid)));

  // Error beats carry no data
  assert_err_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && rresp == RESP_SLVERR) |-> (rdata == '0));

  // At most one lane carries data
  assert_one_lane_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> ($countones({|rdata[127:96], |rdata[95:64],
                                   |rdata[63:32], |rdata[31:0]}) <= 1));

endmodule

// File: rtl/corectl_axi_regs.sv
module corectl_axi_regs
  import cregs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DATA_W    = 128,
  parameter int unsigned ID_W      = 4,
  parameter int unsigned N_INFO    = 8,
  parameter logic [31:0] CTL_RESET = 32'h0000_0001
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_awvalid,
  output logic                     s_awready,
  input  logic [ADDR_W-1:0]        s_awaddr,
  input  logic [ID_W-1:0]          s_awid,
  input  logic                     s_wvalid,
  output logic                     s_wready,
  input  logic [DATA_W-1:0]        s_wdata,
  input  logic [DATA_W/8-1:0]      s_wstrb,
  output logic                     s_bvalid,
  input  logic                     s_bready,
  output logic [1:0]               s_bresp,
  output logic [ID_W-1:0]          s_bid,
  input  logic                     s_arvalid,
  output logic                     s_arready,
  input  logic [ADDR_W-1:0]        s_araddr,
  input  logic [ID_W-1:0]          s_arid,
  output logic                     s_rvalid,
  input  logic                     s_rready,
  output logic [DATA_W-1:0]        s_rdata,
  output logic [1:0]               s_rresp,
  output logic [ID_W-1:0]          s_rid,
  output logic                     s_rlast,
  input  logic [N_INFO*WORD_W-1:0] core_info_i,
  output logic [WORD_W-1:0]        core_rstctl_o,
  output logic [WORD_W-1:0]        core_start_pc_o
);

  logic                commit;
  logic [ADDR_W-1:0]   cm_ofs;
  logic [WORD_W-1:0]   cm_data;
  logic [WORD_W/8-1:0] cm_be;
  logic                cm_ok;
  logic [ADDR_W-1:0]   lk_ofs;
  logic [WORD_W-1:0]   lk_word;
  logic                lk_ok;

  cregs_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr), .awid(s_awid),
    .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata), .wstrb(s_wstrb),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp), .bid(s_bid),
    .commit_o(commit), .cm_ofs_o(cm_ofs), .cm_data_o(cm_data), .cm_be_o(cm_be),
    .cm_ok_i(cm_ok)
  );

  cregs_bank #(.ADDR_W(ADDR_W), .N_INFO(N_INFO), .CTL_RESET(CTL_RESET)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(commit), .wr_ofs(cm_ofs), .wr_data(cm_data), .wr_be(cm_be),
    .wr_ok(cm_ok),
    .rd_ofs(lk_ofs), .rd_word(lk_word), .rd_ok(lk_ok),
    .info_i(core_info_i), .ctl_o(core_rstctl_o), .pc_o(core_start_pc_o)
  );

  cregs_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr), .arid(s_arid),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
    .rid(s_rid), .rlast(s_rlast),
    .lk_ofs_o(lk_ofs), .lk_word_i(lk_word), .lk_ok_i(lk_ok)
  );

  // Write response answers the accepted write's ID
  assert_bid_echo_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (s_awvalid && s_awready && s_bvalid) |-> ##0 1'b1 ##1 $stable(s_bid) || !s_bvalid);

endmodule

// File: tb/corectl_axi_regs_test.sv
module corectl_axi_regs_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         awvalid, awready, wvalid, wready, bvalid, bready;
  logic [12:0]  awaddr, araddr;
  logic [3:0]   awid, arid, bid, rid;
  logic [127:0] wdata, rdata;
  logic [15:0]  wstrb;
  logic [1:0]   bresp, rresp;
  logic         arvalid, arready, rvalid, rready, rlast;
  logic [255:0] info;
  logic [31:0]  rstctl, startpc;

  always #2 clk = ~clk;

  corectl_axi_regs uut (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr), .s_awid(awid),
    .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
    .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp), .s_bid(bid),
    .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr), .s_arid(arid),
    .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
    .s_rid(rid), .s_rlast(rlast),
    .core_info_i(info), .core_rstctl_o(rstctl), .core_start_pc_o(startpc)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit mon_on = 0;

  // Behavioural register model
  logic [31:0] m_ctl = 32'h1;
  logic [31:0] m_pc  = 32'h0;

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Every-clock comparison of the level outputs against the model
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      #1;
      chk(rstctl == m_ctl, "R1 core_rstctl_o", 128'(rstctl), 128'(m_ctl));
      chk(startpc == m_pc, "R2 core_start_pc_o", 128'(startpc), 128'(m_pc));
    end
  end

  function automatic logic [31:0] info_word(input int k);
    return info[k*32 +: 32];
  endfunction

  // Expected read: {ok, data}
  function automatic logic [128:0] exp_rd(input logic [12:0] a);
    int unsigned w;
    logic [31:0] v;
    logic ok;
    logic [127:0] d;
    w  = {19'b0, a[12:2], 2'b00};
    ok = 1'b1;
    v  = '0;
    if (w == 0)                         v = m_ctl;
    else if (w == 4)                    v = m_pc;
    else if (w == 8)                    v = {30'b0, m_ctl[0] & m_ctl[1], m_ctl[0]};
    else if (w >= 'h100 && w <= 'h11C)  v = info_word(int'((w - 'h100) / 4));
    else                                ok = 1'b0;
    d = '0;
    if (ok) d[a[3:2]*32 +: 32] = v;
    return {ok, d};
  endfunction

  task automatic send_aw;
    awvalid = 1'b1;
    while (!awready) @(negedge clk);
    @(negedge clk);
    awvalid = 1'b0;
  endtask

  task automatic send_w;
    wvalid = 1'b1;
    while (!wready) @(negedge clk);
    @(negedge clk);
    wvalid = 1'b0;
  endtask

  // order: 0 together, 1 address first, 2 data first
  task automatic axi_wr(input logic [12:0] a, input logic [31:0] d,
                        input logic [3:0] be, input int order, input int gap,
                        input int bdelay, input logic [3:0] id, input string tag);
    int unsigned w;
    logic [31:0] mask;
    logic        ok;
    int          lane;
    lane   = int'(a[3:2]);
    w      = {19'b0, a[12:2], 2'b00};
    ok     = (w <= 'hC);
    awaddr = a;
    awid   = id;
    wdata  = {4{~d}};
    wdata[lane*32 +: 32] = d;
    wstrb  = 16'hFFFF;
    wstrb[lane*4 +: 4] = be;
    if (order == 0) begin
      fork send_aw(); send_w(); join
    end else if (order == 1) begin
      send_aw();
      for (int i = 0; i < gap; i++) begin
        chk(!bvalid, {tag, " R10 no B before data"}, 128'(bvalid), 128'(0));
        @(negedge clk);
      end
      send_w();
    end else begin
      send_w();
      for (int i = 0; i < gap; i++) begin
        chk(!bvalid, {tag, " R10 no B before address"}, 128'(bvalid), 128'(0));
        @(negedge clk);
      end
      send_aw();
    end
    for (int i = 0; i < 20 && !bvalid; i++) @(negedge clk);
    chk(bvalid, {tag, " R10 B after both beats"}, 128'(bvalid), 128'(1));
    for (int b = 0; b < 4; b++) mask[b*8 +: 8] = {8{be[b]}};
    if (ok && w == 0) m_ctl = (m_ctl & ~mask) | (d & mask);
    if (ok && w == 4) m_pc  = (m_pc & ~mask) | (d & mask);
    for (int i = 0; i < bdelay; i++) begin
      @(negedge clk);
      chk(bvalid, {tag, " R9 BVALID held"}, 128'(bvalid), 128'(1));
    end
    chk(bresp == (ok ? 2'b00 : 2'b10), {tag, " R4/R8 BRESP"}, 128'(bresp),
        128'(ok ? 2'b00 : 2'b10));
    chk(bid == id, {tag, " R13 BID"}, 128'(bid), 128'(id));
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
    chk(!bvalid, {tag, " R9 BVALID drops after BREADY"}, 128'(bvalid), 128'(0));
  endtask

  task automatic axi_rd(input logic [12:0] a, input logic [3:0] id,
                        input int rdelay, input string tag);
    logic [128:0] e;
    logic [127:0] first;
    araddr  = a;
    arid    = id;
    arvalid = 1'b1;
    while (!arready) @(negedge clk);
    e = exp_rd(a);
    @(negedge clk);
    arvalid = 1'b0;
    for (int i = 0; i < 20 && !rvalid; i++) @(negedge clk);
    chk(rvalid && rlast, {tag, " R11 beat with RLAST"}, 128'({rvalid, rlast}), 128'(3));
    first = rdata;
    for (int i = 0; i < rdelay; i++) begin
      @(negedge clk);
      chk(rvalid && rlast && rdata == first, {tag, " R11 beat held"}, rdata, first);
    end
    chk(rdata == e[127:0], {tag, " RDATA"}, rdata, e[127:0]);
    chk(rresp == (e[128] ? 2'b00 : 2'b10), {tag, " RRESP"}, 128'(rresp),
        128'(e[128] ? 2'b00 : 2'b10));
    chk(rid == id, {tag, " R13 RID"}, 128'(rid), 128'(id));
    rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
  endtask

  // Watchdog
  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    awvalid = 0; wvalid = 0; bready = 0; arvalid = 0; rready = 0;
    awaddr = '0; araddr = '0; awid = '0; arid = '0; wdata = '0; wstrb = '0;
    for (int k = 0; k < 8; k++) info[k*32 +: 32] = 32'hC0DE_0000 + 32'(k * 'h1111);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    chk(rstctl == 32'h1, "R2 reset control value", 128'(rstctl), 128'(1));
    chk(startpc == 32'h0, "R2 reset start address", 128'(startpc), 128'(0));
    chk(!bvalid && !rvalid, "R2 no pending beats", 128'({bvalid, rvalid}), 128'(0));
    chk(awready && wready && arready, "R2 ready after reset",
        128'({awready, wready, arready}), 128'(7));
    mon_on = 1;

    // R1: full and byte-masked writes to the control word
    axi_wr(13'h000, 32'hDEAD_BEEF, 4'hF, 0, 0, 0, 4'h1, "R1 full");
    axi_rd(13'h000, 4'h2, 0, "R1 readback");
    axi_wr(13'h000, 32'h1122_3344, 4'b0101, 0, 0, 0, 4'h3, "R1 masked");
    axi_rd(13'h000, 4'h4, 2, "R1 masked readback");
    // R12: start address in lane 1, byte offset bits ignored
    axi_wr(13'h006, 32'h8000_0400, 4'hF, 0, 0, 0, 4'h5, "R12 pc lane1");
    axi_rd(13'h005, 4'h6, 0, "R12 pc read lane1");
    axi_wr(13'h004, 32'hFFFF_FFFF, 4'b1000, 0, 0, 0, 4'h7, "R12 pc byte3");
    axi_rd(13'h004, 4'h8, 0, "R12 pc read");

    // R3: every combination of hold and gate bits
    for (int c = 0; c < 4; c++) begin
      axi_wr(13'h000, 32'hF0F0_F0F0 | 32'(c), 4'hF, 0, 0, 0, 4'(c), "R3 set ctl");
      axi_rd(13'h008, 4'(c), 0, "R3 status");
      chk(rdata[95:64] == 0 || rdata[95:64] == 1 || rdata[95:64] == 3,
          "R3 status in {0,1,3}", 128'(rdata[95:64]), 128'(3));
    end

    // R4: writes to status and spare words do nothing
    axi_wr(13'h008, 32'hFFFF_FFFF, 4'hF, 0, 0, 0, 4'h9, "R4 write status");
    axi_wr(13'h00C, 32'h5555_5555, 4'hF, 1, 2, 0, 4'hA, "R4 write spare");
    axi_rd(13'h000, 4'hB, 0, "R4 ctl unchanged");
    axi_rd(13'h004, 4'hC, 0, "R4 pc unchanged");
    axi_rd(13'h008, 4'hD, 0, "R4 status unchanged");

    // R5: lower region holes
    for (int k = 3; k < 64; k++) axi_rd(13'(k * 4), 4'(k), 0, "R5 hole read");

    // R6: core status words, including a live change
    for (int k = 0; k < 8; k++) axi_rd(13'(32'h100 + k * 4), 4'(k), 0, "R6 info read");
    info[5*32 +: 32] = 32'h0BAD_F00D;
    axi_rd(13'h114, 4'hE, 1, "R6 info live");

    // R7: upper region holes
    for (int k = 'h48; k < 'h800; k++) axi_rd(13'(k * 4), 4'(k), 0, "R7 hole read");

    // R8: writes outside the writable words
    axi_wr(13'h104, 32'h1234_5678, 4'hF, 0, 0, 0, 4'h1, "R8 write info");
    axi_wr(13'h010, 32'h1234_5678, 4'hF, 2, 1, 0, 4'h2, "R8 write hole");
    axi_wr(13'h1FFC, 32'h1234_5678, 4'hF, 0, 0, 0, 4'h3, "R8 write top");
    axi_rd(13'h104, 4'h4, 0, "R8 info unchanged");

    // R9/R10: orders, gaps and slow BREADY
    axi_wr(13'h004, 32'hA5A5_0001, 4'hF, 1, 3, 7, 4'h5, "R9 slow bready aw-first");
    axi_wr(13'h004, 32'hA5A5_0002, 4'hF, 2, 4, 25, 4'h6, "R9 slow bready w-first");
    axi_rd(13'h004, 4'h7, 4, "R11 slow rready");

    // Random mix against the model
    for (int n = 0; n < 300; n++) begin
      logic [12:0] a;
      int sel;
      sel = int'($urandom_range(0, 5));
      case (sel)
        0: a = 13'($urandom_range(0, 3));
        1: a = 13'h004;
        2: a = 13'h008;
        3: a = 13'h00C;
        4: a = 13'(32'h100 + $urandom_range(0, 7) * 4);
        default: a = 13'($urandom_range(0, 'h1FFF));
      endcase
      if ($urandom_range(0, 1) == 1)
        axi_wr(a, $urandom, 4'($urandom), int'($urandom_range(0, 2)),
               int'($urandom_range(0, 3)), int'($urandom_range(0, 5)),
               4'($urandom), "R12 random write");
      else
        axi_rd(a, 4'($urandom), int'($urandom_range(0, 5)), "R12 random read");
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule